// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block drives the timing side of a display pipe. From the pixel clock it produces horizontal sync, vertical sync, a data-enable strobe and the column and row of the active pixel being shown. Software describes the raster through five 32-bit words sent over a plain write port. The words give the sync width, back porch, active size and front porch on each axis, the polarity of each output, an enable bit and a code for the number of output data lines. The code is only passed through, for the downstream driver to read.

Every line runs sync, back porch, active pixels, then front porch. Every frame runs the same four phases, counted in lines. Writes land first in staging registers. A running raster copies them only on the edge that ends a frame, so a frame never mixes two configurations. When the enable bit is cleared, the frame in progress runs to its end, and the block then holds its outputs at their inactive levels.

The encoding differs between the axes. The horizontal sync, porch and size fields are all stored as the count minus one. On the vertical axis, only the sync width and the active height use that offset. The two vertical porches hold their true line counts, so they may be zero.

Top module: `raster_timing_gen`

## Requirements
- R1: Word address 0 is control. Bit 0 is enable, and bits 10:8 are an output data-line width code, which appears on `widthCode` from the cycle after the write. The code values are 0 for 12 lines, 1 for 16, 2 for 18, 3 for 24, 4 for 30 and 5 for 36.
- R2: Address 1 is horizontal timing: bits 7:0 hold sync width minus one, bits 19:8 front porch minus one, and bits 31:20 back porch minus one, all in pixels.
- R3: Address 2 is vertical timing: bits 7:0 hold sync width minus one, while bits 19:8 (front porch) and bits 31:20 (back porch) hold true line counts, zero included.
- R4: Address 3 is active size: bits 11:0 hold width minus one and bits 27:16 hold height minus one.
- R5: Each line is sync, back porch, active, front porch. Horizontal sync is asserted on the first sync-width pixels of every line. Vertical sync is asserted on every pixel of the first sync-width lines of a frame, which is sync, back porch, active, front porch in lines.
- R6: Data enable is asserted only when both axes are in their active regions. There `pixX` and `pixY` give the offset from the first active pixel and line. Elsewhere both are 0.
- R7: Address 4 is polarity. Bit 12 inverts vertical sync, bit 13 inverts horizontal sync and bit 15 inverts data enable. The inactive level of an output equals its invert bit.
- R8: Polarity bits 14, 16, 17 and 18 are stored but have no effect on any output.
- R9: Setting enable while stopped shows pixel (0,0) of the first frame in the second cycle after the write. A timing write during a frame takes effect at the next frame start.
- R10: After reset, and after the frame in which enable was cleared has ended, all syncs and data enable are at their inactive levels and both coordinates are 0.
- R11: Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register word address |
| wrData | input | 32 | Register write data |
| hsyncOut | output | 1 | Horizontal sync, polarity applied |
| vsyncOut | output | 1 | Vertical sync, polarity applied |
| deOut | output | 1 | Data enable, polarity applied |
| pixX | output | 12 | Active column, 0 outside the active area |
| pixY | output | 12 | Active row, 0 outside the active area |
| widthCode | output | 3 | Data-line width code from the control word |

## Verification
The assertions assume that no staging write lands on the very edge that ends a frame, since such a write would arrive one frame later than the software meant. They also assume that the programmed line and frame lengths fit in the counter width. The stimulus places each write a few pixels into a frame and uses small rasters, so the counters stay far below their limit. It still covers zero vertical porches, single-pixel syncs and every polarity bit, including the ones that must be ignored.

// File: rtl/rtg_pkg.sv
`timescale 1ns/1ps
package rtg_pkg;

  localparam int SIZE_W = 12;
  localparam int SYNC_W = 8;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_HTIM = 3'd1;
  localparam logic [2:0] ADDR_VTIM = 3'd2;
  localparam logic [2:0] ADDR_SIZE = 3'd3;
  localparam logic [2:0] ADDR_POL  = 3'd4;

  // decoded raster description, as held in staging and shadow registers
  typedef struct packed {
    logic [SYNC_W-1:0] hSyncM1;
    logic [SIZE_W-1:0] hFrontM1;
    logic [SIZE_W-1:0] hBackM1;
    logic [SYNC_W-1:0] vSyncM1;
    logic [SIZE_W-1:0] vFront;
    logic [SIZE_W-1:0] vBack;
    logic [SIZE_W-1:0] hActM1;
    logic [SIZE_W-1:0] vActM1;
    logic              invV;
    logic              invH;
    logic              invDe;
  } rtg_timing_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic run;
    logic clear;
    logic active;
  } rtg_strobe_t;

  typedef enum logic {ST_IDLE, ST_RUN} rtg_state_t;

endpackage

// File: rtl/rtg_regfile.sv
`timescale 1ns/1ps
module rtg_regfile
  import rtg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  output rtg_timing_t       staged,
  output logic              enable,
  output logic [2:0]        widthCode,
  output logic              unusedPolBits
);

  logic [3:0] polSpare;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      staged    <= '0;
      enable    <= 1'b0;
      widthCode <= '0;
      polSpare  <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_W'(ADDR_CTRL): begin
          enable    <= wrData[0];
          widthCode <= wrData[10:8];
        end
        ADDR_W'(ADDR_HTIM): begin
          staged.hSyncM1  <= wrData[7:0];
          staged.hFrontM1 <= wrData[19:8];
          staged.hBackM1  <= wrData[31:20];
        end
        ADDR_W'(ADDR_VTIM): begin
          staged.vSyncM1 <= wrData[7:0];
          staged.vFront  <= wrData[19:8];
          staged.vBack   <= wrData[31:20];
        end
        ADDR_W'(ADDR_SIZE): begin
          staged.hActM1 <= wrData[11:0];
          staged.vActM1 <= wrData[27:16];
        end
        ADDR_W'(ADDR_POL): begin
          staged.invV  <= wrData[12];
          staged.invH  <= wrData[13];
          staged.invDe <= wrData[15];
          polSpare     <= {wrData[18:16], wrData[14]};
        end
        default: ;
      endcase
    end
  end

  // edge-select and sync-alignment bits are kept but steer nothing here
  assign unusedPolBits = ^polSpare;

endmodule

// File: rtl/rtg_ctrl.sv
`timescale 1ns/1ps
module rtg_ctrl
  import rtg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        frameEnd,
  output rtg_strobe_t strobe
);

  rtg_state_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        strobe.load  = 1'b1;
        strobe.clear = 1'b1;
        if (enable) stateNext = ST_RUN;
      end
      ST_RUN: begin
        strobe.run    = 1'b1;
        strobe.active = 1'b1;
        if (frameEnd) begin
          if (enable) strobe.load = 1'b1;
          else        stateNext   = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R10: a running raster never stops in mid-frame
  a_r10_run_until_frame_end: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !frameEnd) |=> (state == ST_RUN));

  // R9: a stopped raster with enable set starts on the next edge
  a_r9_start_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && enable) |=> strobe.active);

endmodule

// File: rtl/rtg_datapath.sv
`timescale 1ns/1ps
module rtg_datapath
  import rtg_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  rtg_timing_t        staged,
  input  rtg_strobe_t        strobe,
  output logic               frameEnd,
  output logic               hsyncOut,
  output logic               vsyncOut,
  output logic               deOut,
  output logic [COORD_W-1:0] pixX,
  output logic [COORD_W-1:0] pixY
);

  rtg_timing_t sh;
  logic [CNT_W-1:0] hCnt, vCnt;
  logic [CNT_W-1:0] hSyncLen, hActStart, hActEnd, hLast;
  logic [CNT_W-1:0] vSyncLen, vActStart, vActEnd, vLast;
  logic lineEnd, hInAct, vInAct, deActive, hSyncAct, vSyncAct;

  // shadow copy: follows staging while stopped, reloads only at frame end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            sh <= '0;
    else if (strobe.load) sh <= staged;
  end

  // horizontal offsets: every field carries a minus-one offset
  always_comb begin
    hSyncLen  = CNT_W'(sh.hSyncM1) + CNT_W'(1);
    hActStart = hSyncLen + CNT_W'(sh.hBackM1) + CNT_W'(1);
    hActEnd   = hActStart + CNT_W'(sh.hActM1) + CNT_W'(1);
    hLast     = hActEnd + CNT_W'(sh.hFrontM1);
  end

  // vertical offsets: porches are true counts, sync and size minus one
  always_comb begin
    vSyncLen  = CNT_W'(sh.vSyncM1) + CNT_W'(1);
    vActStart = vSyncLen + CNT_W'(sh.vBack);
    vActEnd   = vActStart + CNT_W'(sh.vActM1) + CNT_W'(1);
    vLast     = vActEnd + CNT_W'(sh.vFront) - CNT_W'(1);
  end

  assign lineEnd  = (hCnt == hLast);
  assign frameEnd = lineEnd && (vCnt == vLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (strobe.clear) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (strobe.run) begin
      if (lineEnd) begin
        hCnt <= '0;
        vCnt <= frameEnd ? '0 : vCnt + CNT_W'(1);
      end else begin
        hCnt <= hCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    hSyncAct = strobe.active && (hCnt < hSyncLen);
    vSyncAct = strobe.active && (vCnt < vSyncLen);
    hInAct   = (hCnt >= hActStart) && (hCnt < hActEnd);
    vInAct   = (vCnt >= vActStart) && (vCnt < vActEnd);
    deActive = strobe.active && hInAct && vInAct;
    hsyncOut = hSyncAct ^ sh.invH;
    vsyncOut = vSyncAct ^ sh.invV;
    deOut    = deActive ^ sh.invDe;
    pixX     = deActive ? COORD_W'(hCnt - hActStart) : '0;
    pixY     = deActive ? COORD_W'(vCnt - vActStart) : '0;
  end

  // R5: counters stay inside the programmed raster
  a_r5_counter_bound: assert property (@(posedge clk) disable iff (!rstN)
    strobe.active |-> (hCnt <= hLast && vCnt <= vLast));

  // R6: coordinates never pass the programmed active size
  a_r6_coord_bound: assert property (@(posedge clk) disable iff (!rstN)
    (deOut != sh.invDe) |-> (pixX <= COORD_W'(sh.hActM1) && pixY <= COORD_W'(sh.vActM1)));

  // R6: data enable never overlaps horizontal sync
  a_r6_de_outside_sync: assert property (@(posedge clk) disable iff (!rstN)
    (deOut != sh.invDe) |-> (hsyncOut == sh.invH));

  // R9: the configuration is held for the whole of a running frame
  a_r9_shadow_held: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && !frameEnd) |=> $stable(sh));

  // R10: a stopped raster shows only inactive levels
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.active |-> (pixX == '0 && pixY == '0 && hsyncOut == sh.invH
                        && vsyncOut == sh.invV && deOut == sh.invDe));

endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [31:0] wrData,
  output logic        hsyncOut,
  output logic        vsyncOut,
  output logic        deOut,
  output logic [11:0] pixX,
  output logic [11:0] pixY,
  output logic [2:0]  widthCode
);

  localparam int COORD_W = SIZE_W;
  localparam int ADDR_W  = 3;

  rtg_timing_t staged;
  rtg_strobe_t strobe;
  logic        enable;
  logic        frameEnd;
  logic        unusedPolBits;

  rtg_regfile #(.ADDR_W(ADDR_W)) uRegs (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .staged       (staged),
    .enable       (enable),
    .widthCode    (widthCode),
    .unusedPolBits(unusedPolBits)
  );

  rtg_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .frameEnd(frameEnd),
    .strobe  (strobe)
  );

  rtg_datapath #(.CNT_W(CNT_W), .COORD_W(COORD_W)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .staged  (staged),
    .strobe  (strobe),
    .frameEnd(frameEnd),
    .hsyncOut(hsyncOut),
    .vsyncOut(vsyncOut),
    .deOut   (deOut),
    .pixX    (pixX),
    .pixY    (pixY)
  );

endmodule

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic        wrEn;
  logic [2:0]  wrAddr;
  logic [31:0] wrData;
  logic        hsyncOut, vsyncOut, deOut;
  logic [11:0] pixX, pixY;
  logic [2:0]  widthCode;

  raster_timing_gen dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut),
    .pixX(pixX), .pixY(pixY), .widthCode(widthCode)
  );

  typedef struct packed {
    logic [15:0] hsw, hbp, hact, hfp;
    logic [15:0] vsw, vbp, vact, vfp;
    logic [31:0] pol;
  } cfg_t;

  // true counts; pol holds the polarity word as written
  localparam int NV = 4;
  localparam cfg_t VEC [NV] = '{
    '{16'd2, 16'd3, 16'd8, 16'd2, 16'd1, 16'd2, 16'd4, 16'd1, 32'h0000_0000},
    '{16'd1, 16'd1, 16'd4, 16'd1, 16'd2, 16'd0, 16'd3, 16'd0, 32'h0000_B000},
    '{16'd3, 16'd2, 16'd5, 16'd4, 16'd1, 16'd1, 16'd2, 16'd3, 32'h0007_6000},
    '{16'd1, 16'd2, 16'd3, 16'd1, 16'd1, 16'd3, 16'd2, 16'd2, 32'h0000_9000}
  };

  int  checks = 0;
  int  errors = 0;
  logic done = 1'b0;

  function automatic logic [31:0] hWord(input cfg_t c);
    logic [15:0] s, f, b;
    s = c.hsw - 16'd1; f = c.hfp - 16'd1; b = c.hbp - 16'd1;
    return {b[11:0], f[11:0], s[7:0]};
  endfunction

  function automatic logic [31:0] vWord(input cfg_t c);
    logic [15:0] s;
    s = c.vsw - 16'd1;
    return {c.vbp[11:0], c.vfp[11:0], s[7:0]};
  endfunction

  function automatic logic [31:0] sizeWord(input cfg_t c);
    logic [15:0] w, h;
    w = c.hact - 16'd1; h = c.vact - 16'd1;
    return {4'd0, h[11:0], 4'd0, w[11:0]};
  endfunction

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadCfg(input cfg_t c);
    writeReg(3'd1, hWord(c));
    writeReg(3'd2, vWord(c));
    writeReg(3'd3, sizeWord(c));
    writeReg(3'd4, c.pol);
  endtask

  task automatic checkCode(input logic [2:0] exp, input string tag);
    checks++;
    if (widthCode !== exp) begin
      errors++;
      $display("FAIL %s: widthCode got %0d expected %0d", tag, widthCode, exp);
    end
  endtask

  // walks one frame pixel by pixel; optionally issues one write at pixel wrAt
  task automatic checkFrame(input cfg_t c, input string tag, input int wrAt,
                            input logic [2:0] wa, input logic [31:0] wd);
    int hTot, vTot, bad, badP;
    logic gHs, gVs, gDe, eHs, eVs, eDe;
    int gX, gY, eX, eY;
    hTot = int'(c.hsw) + int'(c.hbp) + int'(c.hact) + int'(c.hfp);
    vTot = int'(c.vsw) + int'(c.vbp) + int'(c.vact) + int'(c.vfp);
    bad = 0; badP = 0;
    {gHs, gVs, gDe, eHs, eVs, eDe} = '0;
    gX = 0; gY = 0; eX = 0; eY = 0;
    for (int p = 0; p < hTot * vTot; p++) begin
      int h, v, hs0, vs0;
      logic hA, vA, xHs, xVs, xDe;
      int xX, xY;
      @(negedge clk);
      if (p == wrAt) begin
        wrEn = 1'b1; wrAddr = wa; wrData = wd;
      end else begin
        wrEn = 1'b0;
      end
      h = p % hTot; v = p / hTot;
      hs0 = int'(c.hsw) + int'(c.hbp);
      vs0 = int'(c.vsw) + int'(c.vbp);
      hA = (h >= hs0) && (h < hs0 + int'(c.hact));
      vA = (v >= vs0) && (v < vs0 + int'(c.vact));
      xHs = (h < int'(c.hsw)) ^ c.pol[13];
      xVs = (v < int'(c.vsw)) ^ c.pol[12];
      xDe = (hA && vA) ^ c.pol[15];
      xX = (hA && vA) ? h - hs0 : 0;
      xY = (hA && vA) ? v - vs0 : 0;
      if (hsyncOut !== xHs || vsyncOut !== xVs || deOut !== xDe ||
          int'(pixX) != xX || int'(pixY) != xY) begin
        if (bad == 0) begin
          badP = p; gHs = hsyncOut; gVs = vsyncOut; gDe = deOut;
          gX = int'(pixX); gY = int'(pixY);
          eHs = xHs; eVs = xVs; eDe = xDe; eX = xX; eY = xY;
        end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: pixel %0d got hs=%b vs=%b de=%b x=%0d y=%0d expected hs=%b vs=%b de=%b x=%0d y=%0d",
               tag, badP, gHs, gVs, gDe, gX, gY, eHs, eVs, eDe, eX, eY);
    end
  endtask

  task automatic checkIdle(input cfg_t c, input string tag, input int n);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (hsyncOut !== c.pol[13] || vsyncOut !== c.pol[12] || deOut !== c.pol[15] ||
          pixX !== 12'd0 || pixY !== 12'd0) begin
        if (bad == 0)
          $display("FAIL %s: idle cycle %0d got hs=%b vs=%b de=%b x=%0d y=%0d expected hs=%b vs=%b de=%b x=0 y=0",
                   tag, i, hsyncOut, vsyncOut, deOut, pixX, pixY, c.pol[13], c.pol[12], c.pol[15]);
        bad++;
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R5 watchdog: got no completion, expected completion within limit");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cfg_t cB;
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state: all outputs inactive with zero polarity, code 0
    checks++;
    if (hsyncOut !== 1'b0 || vsyncOut !== 1'b0 || deOut !== 1'b0 ||
        pixX !== 12'd0 || pixY !== 12'd0 || widthCode !== 3'd0) begin
      errors++;
      $display("FAIL R10 reset: got hs=%b vs=%b de=%b x=%0d y=%0d code=%0d expected all 0",
               hsyncOut, vsyncOut, deOut, pixX, pixY, widthCode);
    end

    // table walk: R2 R3 R4 R5 R6 R7 R8 shape, R1 code, R10 stop after the frame
    for (int i = 0; i < NV; i++) begin
      logic [2:0] code;
      code = 3'(i + 2);
      loadCfg(VEC[i]);
      writeReg(3'd0, {21'd0, code, 7'd0, 1'b1});
      checkCode(code, "R1 width code");
      checkFrame(VEC[i], "R2 R3 R4 R5 R6 R7 R8 R9 frame", 1, 3'd0, 32'd0);
      checkIdle(VEC[i], "R10 stop after frame", 6);
    end

    // R9: horizontal rewrite mid-frame applies only from the next frame
    cB = VEC[0];
    cB.hsw = VEC[2].hsw; cB.hbp = VEC[2].hbp; cB.hfp = VEC[2].hfp;
    loadCfg(VEC[0]);
    writeReg(3'd0, 32'h0000_0001);
    checkFrame(VEC[0], "R9 old config held", 5, 3'd1, hWord(cB));
    checkFrame(cB, "R9 new config at next frame", 1, 3'd0, 32'd0);
    checkIdle(cB, "R10 stop after frame", 6);

    // R11: unused address write leaves raster and code unchanged
    loadCfg(VEC[3]);
    writeReg(3'd0, 32'h0000_0101);
    checkFrame(VEC[3], "R11 frame during unused write", 2, 3'd5, 32'hFFFF_FFFF);
    checkCode(3'd1, "R11 code after unused write");
    checkFrame(VEC[3], "R11 frame after unused write", 1, 3'd0, 32'd0);
    checkIdle(VEC[3], "R10 stop after frame", 6);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule